// File: doc/BRIEF.md
# Carry and Overflow Add/Subtract Unit

A 32-bit integer add and subtract unit that keeps three status flags: a carry flag, an overflow flag and a sticky summary-overflow flag. Each accepted operation computes a result from two register operands, an immediate, or the stored carry. It then updates the flags according to that operation's carry rule and the overflow-enable bit.

Subtraction is done in "subtract-from" style: the second operand plus the complement of the first, plus a carry-in. The extended forms take their carry-in from the stored carry flag. A dependent extended operation can therefore be issued on the very next cycle. Results and flags are registered. They change on the rising clock edge at which the input strobe is high.

Top module: `addsub_flag_unit`

## Requirements
- R1: During and after reset, `res` is 0 and `ca`, `ov` and `so` are 0.
- R2: The `op` codes are: 0 add, 1 add carrying, 2 add extended, 3 add-immediate carrying, 4 add-minus-one extended, 5 add-zero extended, 6 subtract-from, 7 subtract-from carrying, 8 subtract-from extended, 9 subtract-from-immediate carrying, 10 subtract-from minus-one extended, 11 subtract-from zero extended, 12 negate. Codes 0, 1 and 2 give a+b, a+b and a+b+ca. Code 3 gives a+imm.
- R3: Add extended sets carry when the sum is below `a`, or when the stored carry was 1 and the sum equals `a`. Otherwise it clears carry.
- R4: Subtract-from gives b+~a+1; the extended form gives b+~a+ca. Carry is set when no borrow occurs (b >= a, counting the carry-in). Subtract-from-immediate carrying gives imm+~a+1 and sets carry exactly when the result is less than or equal to `imm`.
- R5: Add-minus-one gives a+ca-1 and add-zero gives a+ca. Subtract-from minus-one gives ~a+ca-1 and subtract-from zero gives ~a+ca. Each sets carry from the carry out of bit 31.
- R6: Negate gives ~a+1. The value 0x80000000 negates to itself and is the only input that raises overflow.
- R7: Signed overflow is the case where both summands share a sign and the result's sign differs; for add-minus-one this means `a` was negative and the result is not. With `ov_en` high and overflow detected, both `ov` and `so` become 1.
- R8: With `ov_en` high and no overflow, `ov` is cleared and `so` keeps its value. With `ov_en` low, `ov` and `so` both keep their values.
- R9: Codes 0, 6 and 12 leave the carry flag unchanged.
- R10: When `in_valid` is low, or `op` is 13 to 15, the result and all flags keep their values.
- R11: `so` stays at 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: accept the operation this cycle |
| op | input | 4 | Operation code (see R2) |
| ov_en | input | 1 | Overflow-enabled form of the operation |
| a | input | 32 | First operand (the subtrahend in subtract-from) |
| b | input | 32 | Second operand |
| imm | input | 32 | Immediate operand |
| res | output | 32 | Registered result |
| ca | output | 1 | Carry flag |
| ov | output | 1 | Overflow flag |
| so | output | 1 | Sticky summary-overflow flag |

## Verification
Several properties are checked on every accepted cycle:
- the extended-add carry rule, the immediate-subtract carry rule and the negate-overflow rule, each restated as comparisons rather than as a carry-out bit;
- stability of carry under the non-carrying codes;
- holding of all state while idle or on unused codes;
- the fact that `ov` implies `so`, and that `so` is sticky.

Only the bench's scenarios show that the arithmetic results are correct and that carries chain correctly from one operation into a dependent extended one. They also show that the add-minus-one and complement-based variants produce the right carries, and that reset clears a set `so`.

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic         ov_en,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] imm,
  output logic [W-1:0] res,
  output logic         ca,
  output logic         ov,
  output logic         so
);
  localparam logic [3:0] OP_ADD   = 4'd0,  OP_ADDC  = 4'd1,  OP_ADDE   = 4'd2,
                         OP_ADDIC = 4'd3,  OP_ADDME = 4'd4,  OP_ADDZE  = 4'd5,
                         OP_SUBF  = 4'd6,  OP_SUBFC = 4'd7,  OP_SUBFE  = 4'd8,
                         OP_SUBFIC= 4'd9,  OP_SUBME = 4'd10, OP_SUBZE  = 4'd11,
                         OP_NEG   = 4'd12;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [W-1:0] x, y;
  logic         cin, carrying, known;
  logic [W:0]   sum;
  logic         ovf, fire;

  always_comb begin
    x = a; y = b; cin = 1'b0; carrying = 1'b1; known = 1'b1;
    case (op)
      OP_ADD:    carrying = 1'b0;
      OP_ADDC:   ;
      OP_ADDE:   cin = ca;
      OP_ADDIC:  y = imm;
      OP_ADDME:  begin y = ONES; cin = ca; end
      OP_ADDZE:  begin y = '0; cin = ca; end
      OP_SUBF:   begin x = ~a; cin = 1'b1; carrying = 1'b0; end
      OP_SUBFC:  begin x = ~a; cin = 1'b1; end
      OP_SUBFE:  begin x = ~a; cin = ca; end
      OP_SUBFIC: begin x = ~a; y = imm; cin = 1'b1; end
      OP_SUBME:  begin x = ~a; y = ONES; cin = ca; end
      OP_SUBZE:  begin x = ~a; y = '0; cin = ca; end
      OP_NEG:    begin x = ~a; y = '0; cin = 1'b1; carrying = 1'b0; end
      default:   begin known = 1'b0; carrying = 1'b0; end
    endcase
  end

  assign sum  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
  assign fire = in_valid && known;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res <= '0; ca <= 1'b0; ov <= 1'b0; so <= 1'b0;
    end else if (fire) begin
      res <= sum[W-1:0];
      if (carrying) ca <= sum[W];
      if (ov_en) begin
        ov <= ovf;
        if (ovf) so <= 1'b1;
      end
    end
  end

  p_adde_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_ADDE |=>
      ca == ((res < $past(a)) || ($past(ca) && res == $past(a))));

  p_subfic_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_SUBFIC |=> ca == (res <= $past(imm)));

  p_neg_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_NEG && ov_en |=> ov == ($past(a) == {1'b1, {(W-1){1'b0}}}));

  p_ov_implies_so_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ov |-> so);

  p_no_ov_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ov_en |=> $stable(ov) && $stable(so));

  p_carry_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD || op == OP_SUBF || op == OP_NEG) |=> $stable(ca));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || op > OP_NEG) |=> $stable(res) && $stable(ca) && $stable(ov) && $stable(so));

  p_so_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    so |=> so);
endmodule

// File: tb/tb_addsub_flag_unit.sv
`timescale 1ns/1ps
module tb_addsub_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic        ov_en = 1'b0;
  logic [31:0] a = '0, b = '0, imm = '0;
  logic [31:0] res;
  logic        ca, ov, so;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  addsub_flag_unit dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .ov_en(ov_en), .a(a), .b(b), .imm(imm), .res(res), .ca(ca), .ov(ov), .so(so));

  always #4 clk = ~clk;

  localparam int N = 18;
  // {op, ov_en, a, b, imm, expected res, expected {ca,ov,so}}; runs in order, flags chain
  localparam logic [135:0] VEC [N] = '{
    {4'd0,  1'b0, 32'd5,        32'd7,        32'd0,        32'd12,       3'b000},
    {4'd1,  1'b0, 32'hFFFFFFFF, 32'd2,        32'd0,        32'd1,        3'b100},
    {4'd2,  1'b0, 32'd1,        32'd1,        32'd0,        32'd3,        3'b000},
    {4'd1,  1'b1, 32'h7FFFFFFF, 32'd1,        32'd0,        32'h80000000, 3'b011},
    {4'd0,  1'b1, 32'd1,        32'd2,        32'd0,        32'd3,        3'b001},
    {4'd7,  1'b0, 32'd3,        32'd10,       32'd0,        32'd7,        3'b101},
    {4'd8,  1'b0, 32'd5,        32'd5,        32'd0,        32'd0,        3'b101},
    {4'd2,  1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0,        32'hFFFFFFFF, 3'b101},
    {4'd9,  1'b0, 32'd6,        32'd0,        32'd5,        32'hFFFFFFFF, 3'b001},
    {4'd4,  1'b1, 32'd0,        32'd0,        32'd0,        32'hFFFFFFFF, 3'b001},
    {4'd4,  1'b1, 32'h80000000, 32'd0,        32'd0,        32'h7FFFFFFF, 3'b111},
    {4'd5,  1'b1, 32'h7FFFFFFF, 32'd0,        32'd0,        32'h80000000, 3'b011},
    {4'd12, 1'b1, 32'h80000000, 32'd0,        32'd0,        32'h80000000, 3'b011},
    {4'd12, 1'b1, 32'd5,        32'd0,        32'd0,        32'hFFFFFFFB, 3'b001},
    {4'd6,  1'b0, 32'd1,        32'd0,        32'd0,        32'hFFFFFFFF, 3'b001},
    {4'd11, 1'b0, 32'hFFFFFFFF, 32'd0,        32'd0,        32'd0,        3'b001},
    {4'd10, 1'b0, 32'd0,        32'd0,        32'd0,        32'hFFFFFFFE, 3'b101},
    {4'd3,  1'b0, 32'd10,       32'd0,        32'hFFFFFFF6, 32'd0,        3'b101}
  };
  localparam string REQ [N] = '{
    "R2 R9", "R2", "R2 R3", "R2 R7", "R8 R9", "R4", "R4", "R3", "R4",
    "R5 R8", "R5 R7", "R5 R7", "R6 R9", "R6 R8", "R4 R9", "R5", "R5", "R2"
  };

  task automatic check(string req, logic [34:0] got, logic [34:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got res=%h flags(ca,ov,so)=%b expected res=%h flags=%b",
               req, got[34:3], got[2:0], exp[34:3], exp[2:0]);
    end
  endtask

  task automatic issue(logic [3:0] o, logic e, logic [31:0] va, logic [31:0] vb,
                       logic [31:0] vi, logic v);
    @(negedge clk);
    op = o; ov_en = e; a = va; b = vb; imm = vi; in_valid = v;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {res, ca, ov, so}, 35'd0);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      issue(VEC[i][135:132], VEC[i][131], VEC[i][130:99], VEC[i][98:67],
            VEC[i][66:35], 1'b1);
      check(REQ[i], {res, ca, ov, so}, VEC[i][34:0]);
    end
    // R10: strobe low, then unused code 13, leave state as after last vector
    issue(4'd0, 1'b1, 32'h7FFFFFFF, 32'd1, 32'd0, 1'b0);
    check("R10 idle", {res, ca, ov, so}, {32'd0, 3'b101});
    issue(4'd13, 1'b1, 32'h7FFFFFFF, 32'd1, 32'd0, 1'b1);
    check("R10 unused op", {res, ca, ov, so}, {32'd0, 3'b101});
    // R11/R1: reset clears sticky so
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R11 R1 so cleared by reset", {res, ca, ov, so}, 35'd0);
    // R8: ov_en low keeps a set ov
    issue(4'd0, 1'b1, 32'h7FFFFFFF, 32'd1, 32'd0, 1'b1);
    check("R7 add overflow", {res, ca, ov, so}, {32'h80000000, 3'b011});
    issue(4'd0, 1'b0, 32'd1, 32'd1, 32'd0, 1'b1);
    check("R8 ov kept when disabled", {res, ca, ov, so}, {32'd2, 3'b011});
    // R11: no-overflow enabled op keeps so
    issue(4'd6, 1'b1, 32'd1, 32'd4, 32'd0, 1'b1);
    check("R11 so sticky", {res, ca, ov, so}, {32'd3, 3'b001});
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule